// File: doc/BRIEF.md
# Two-Level I/O Page Table Walker

This block resolves TLB misses for an I/O translation unit. Each miss carries a 32-bit I/O virtual address, a read/write flag and the requesting client's ASID configuration word. If that word enables translation, the walker looks up the directory base for the ASID. It then reads one directory word and one leaf word through a single-beat word-read port and returns a response. The response is either a refill (physical address plus effective permissions) or a fault with a status code. If the client word does not enable translation, the address passes straight through and no memory is read.

Directory bases are held in one register per ASID inside the block. Software selects an ASID by writing an index register. It then writes a data word holding the directory frame number in its low bits. The index stays in place, so several data writes may follow one index write. The walker handles one miss at a time.

Top module: `iopt_walker`

## Requirements
- R1: The directory read address is {base frame, VA[31:22], 2'b00}, where the base frame is the low PA_BITS-12 bits of the word last written to the data register for that ASID.
- R2: The leaf read address is {directory entry bits [PA_BITS-13:0], VA[21:12], 2'b00}. A refill returns status 0 and physical address {leaf entry bits [PA_BITS-13:0], VA[11:0]}.
- R3: A data-register write stores into the ASID held in the index register, and that index persists across data writes. A stored word of zero, or an ASID never written, marks the base not present. A miss on such an ASID returns status 1 without any memory read.
- R4: A directory entry that is zero, or that has bit 28 (next-level) clear, returns status 1 after exactly one memory read.
- R5: A leaf entry of zero returns status 1 after exactly two memory reads.
- R6: A write needs bit 30 set in both the directory and leaf entries, and a read needs bit 31 set in both. Otherwise the response has status 2.
- R7: When bit 31 of the client word is clear, the response has status 0 and a physical address equal to the zero-extended VA, with no memory read. When bit 31 is set, the ASID is taken from bits 6:0.
- R8: miss_ready is high only while idle. rsp_valid is a one-cycle pulse that echoes the ASID and VA, and the walker is ready again in the next cycle.
- R9: rsp_perm is {readable, writable, nonsecure}: the first two are ANDed across both levels and the third comes from leaf bit 29. It is zero on faults and on passthrough, and rsp_pa is zero on faults.
- R10: mem_req is a one-cycle pulse per read, and the walker waits any number of cycles for mem_rvalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_idx_we | input | 1 | Write strobe for the ASID index register |
| cfg_idx_wdata | input | ASID_W | ASID to select |
| cfg_dat_we | input | 1 | Write strobe for the base data register |
| cfg_dat_wdata | input | 32 | Directory frame number in the low bits, attributes in the top bits |
| miss_valid | input | 1 | Miss request valid |
| miss_ready | output | 1 | Walker idle and accepting |
| miss_va | input | 32 | Virtual address of the miss |
| miss_client_cfg | input | 32 | Client word: bit 31 enable, bits 6:0 ASID |
| miss_write | input | 1 | 1 for a write access, 0 for a read access |
| mem_req | output | 1 | Word read request pulse |
| mem_addr | output | PA_BITS | Byte address of the word to read |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| rsp_valid | output | 1 | Response pulse |
| rsp_status | output | 2 | 0 refill, 1 translation fault, 2 permission fault |
| rsp_asid | output | ASID_W | ASID of the answered miss |
| rsp_va | output | 32 | VA of the answered miss |
| rsp_pa | output | PA_BITS | Translated physical address |
| rsp_pa | output | PA_BITS | Translated physical address |
| rsp_perm | output | 3 | {readable, writable, nonsecure} |

## Verification
The bench builds the walker with PA_BITS=34, ASID_W=7 and directory-permission merging on. The 22-bit frame numbers therefore place table and page addresses above the 4 GiB line, and bits [33:32] of every address get exercised. Because merging is on, a leaf grant can be withdrawn by a directory entry without that grant. With the full 7-bit ASID space, unprogrammed, cleared and reprogrammed bases can be mixed with live ones. The memory responder adds random latency of one to seven cycles, and random entries cover every fault class next to directed corner cases.

// File: rtl/iopt_pkg.sv
package iopt_pkg;

   typedef enum logic [1:0] {
      ST_OK    = 2'd0,
      ST_XLATE = 2'd1,
      ST_PERM  = 2'd2
   } walk_status_e;

   typedef enum logic [2:0] {
      W_IDLE,
      W_DREQ,
      W_DWAIT,
      W_LREQ,
      W_LWAIT,
      W_RESP
   } walk_state_e;

   localparam int unsigned VA_W       = 32;
   localparam int unsigned PG_SHIFT   = 12;
   localparam int unsigned IDX_W      = 10;
   localparam int unsigned BIT_RD     = 31;
   localparam int unsigned BIT_WR     = 30;
   localparam int unsigned BIT_NS     = 29;
   localparam int unsigned BIT_NEXT   = 28;
   localparam int unsigned BIT_CL_EN  = 31;

endpackage

// File: rtl/iopt_base_table.sv
module iopt_base_table #(
   parameter int unsigned ASID_W = 7,
   parameter int unsigned FW     = 22
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              idx_we,
   input  logic [ASID_W-1:0] idx_wdata,
   input  logic              dat_we,
   input  logic [31:0]       dat_wdata,
   input  logic [ASID_W-1:0] rd_asid,
   output logic [FW-1:0]     rd_frame,
   output logic              rd_present
);
   localparam int unsigned NUM = 1 << ASID_W;

   logic [ASID_W-1:0] idx_q;
   logic [NUM-1:0]    pres_q;
   logic [FW-1:0]     frame_q [NUM];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q  <= '0;
         pres_q <= '0;
      end else begin
         if (idx_we) idx_q <= idx_wdata;
         if (dat_we) pres_q[idx_q] <= |dat_wdata;
      end
   end

   always_ff @(posedge clk) begin
      if (dat_we) frame_q[idx_q] <= dat_wdata[FW-1:0];
   end

   assign rd_frame   = frame_q[rd_asid];
   assign rd_present = pres_q[rd_asid];

   // R3: a data write lands on the previously selected index
   p_base_store_r3: assert property (@(posedge clk) disable iff (!rst_n)
      dat_we |=> (pres_q[$past(idx_q)] == $past(|dat_wdata)));

endmodule

// File: rtl/iopt_entry_check.sv
module iopt_entry_check #(
   parameter int unsigned FW             = 22,
   parameter int unsigned DIR_PERM_MERGE = 1
) (
   input  logic [31:0]   dir_word,
   input  logic [31:0]   leaf_word,
   input  logic          is_write,
   output logic          dir_ok,
   output logic          leaf_present,
   output logic          perm_ok,
   output logic [2:0]    perm,
   output logic [FW-1:0] leaf_frame
);
   import iopt_pkg::*;

   logic eff_rd, eff_wr;

   assign dir_ok       = (dir_word != 32'd0) && dir_word[BIT_NEXT];
   assign leaf_present = (leaf_word != 32'd0);
   assign leaf_frame   = leaf_word[FW-1:0];

   generate
      if (DIR_PERM_MERGE != 0) begin : g_merge
         assign eff_rd = leaf_word[BIT_RD] & dir_word[BIT_RD];
         assign eff_wr = leaf_word[BIT_WR] & dir_word[BIT_WR];
      end else begin : g_leaf_only
         assign eff_rd = leaf_word[BIT_RD];
         assign eff_wr = leaf_word[BIT_WR];
      end
   endgenerate

   assign perm_ok = is_write ? eff_wr : eff_rd;
   assign perm    = {eff_rd, eff_wr, leaf_word[BIT_NS]};

endmodule

// File: rtl/iopt_walker.sv
module iopt_walker #(
   parameter int unsigned PA_BITS        = 34,
   parameter int unsigned ASID_W         = 7,
   parameter int unsigned DIR_PERM_MERGE = 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_idx_we,
   input  logic [ASID_W-1:0]  cfg_idx_wdata,
   input  logic               cfg_dat_we,
   input  logic [31:0]        cfg_dat_wdata,
   input  logic               miss_valid,
   output logic               miss_ready,
   input  logic [31:0]        miss_va,
   input  logic [31:0]        miss_client_cfg,
   input  logic               miss_write,
   output logic               mem_req,
   output logic [PA_BITS-1:0] mem_addr,
   input  logic               mem_rvalid,
   input  logic [31:0]        mem_rdata,
   output logic               rsp_valid,
   output logic [1:0]         rsp_status,
   output logic [ASID_W-1:0]  rsp_asid,
   output logic [31:0]        rsp_va,
   output logic [PA_BITS-1:0] rsp_pa,
   output logic [2:0]         rsp_perm
);
   import iopt_pkg::*;

   localparam int unsigned FW = PA_BITS - PG_SHIFT;

   generate
      if (PA_BITS < VA_W || FW > BIT_NEXT) begin : g_bad_pa
         $error("iopt_walker: PA_BITS must lie in 32..40");
      end
      if (ASID_W < 1 || ASID_W > 7) begin : g_bad_asid
         $error("iopt_walker: ASID_W must lie in 1..7");
      end
   endgenerate

   walk_state_e        state_q;
   walk_status_e       status_q;
   logic [31:0]        va_q;
   logic [ASID_W-1:0]  asid_q;
   logic               wr_q;
   logic               xlate_q;
   logic [FW-1:0]      base_q;
   logic [31:0]        pde_q;
   logic [PA_BITS-1:0] pa_q;
   logic [2:0]         perm_q;

   logic [FW-1:0]      bt_frame;
   logic               bt_present;
   logic [PA_BITS-1:0] va_ext;
   logic [31:0]        dir_sel;
   logic               ec_dir_ok, ec_leaf_present, ec_perm_ok;
   logic [2:0]         ec_perm;
   logic [FW-1:0]      ec_leaf_frame;

   iopt_base_table #(.ASID_W(ASID_W), .FW(FW)) u_bases (
      .clk        (clk),
      .rst_n      (rst_n),
      .idx_we     (cfg_idx_we),
      .idx_wdata  (cfg_idx_wdata),
      .dat_we     (cfg_dat_we),
      .dat_wdata  (cfg_dat_wdata),
      .rd_asid    (miss_client_cfg[ASID_W-1:0]),
      .rd_frame   (bt_frame),
      .rd_present (bt_present)
   );

   assign dir_sel = (state_q == W_DWAIT) ? mem_rdata : pde_q;

   iopt_entry_check #(.FW(FW), .DIR_PERM_MERGE(DIR_PERM_MERGE)) u_check (
      .dir_word     (dir_sel),
      .leaf_word    (mem_rdata),
      .is_write     (wr_q),
      .dir_ok       (ec_dir_ok),
      .leaf_present (ec_leaf_present),
      .perm_ok      (ec_perm_ok),
      .perm         (ec_perm),
      .leaf_frame   (ec_leaf_frame)
   );

   always_comb begin
      va_ext       = '0;
      va_ext[31:0] = miss_va;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= W_IDLE;
         status_q <= ST_OK;
         va_q     <= '0;
         asid_q   <= '0;
         wr_q     <= 1'b0;
         xlate_q  <= 1'b0;
         base_q   <= '0;
         pde_q    <= '0;
         pa_q     <= '0;
         perm_q   <= '0;
      end else begin
         case (state_q)
            W_IDLE: begin
               if (miss_valid) begin
                  va_q     <= miss_va;
                  asid_q   <= miss_client_cfg[ASID_W-1:0];
                  wr_q     <= miss_write;
                  xlate_q  <= miss_client_cfg[BIT_CL_EN];
                  base_q   <= bt_frame;
                  pa_q     <= '0;
                  perm_q   <= '0;
                  status_q <= ST_OK;
                  if (!miss_client_cfg[BIT_CL_EN]) begin
                     pa_q    <= va_ext;
                     state_q <= W_RESP;
                  end else if (!bt_present) begin
                     status_q <= ST_XLATE;
                     state_q  <= W_RESP;
                  end else begin
                     state_q <= W_DREQ;
                  end
               end
            end
            W_DREQ: state_q <= W_DWAIT;
            W_DWAIT: begin
               if (mem_rvalid) begin
                  pde_q <= mem_rdata;
                  if (!ec_dir_ok) begin
                     status_q <= ST_XLATE;
                     state_q  <= W_RESP;
                  end else begin
                     state_q <= W_LREQ;
                  end
               end
            end
            W_LREQ: state_q <= W_LWAIT;
            W_LWAIT: begin
               if (mem_rvalid) begin
                  if (!ec_leaf_present) begin
                     status_q <= ST_XLATE;
                  end else if (!ec_perm_ok) begin
                     status_q <= ST_PERM;
                  end else begin
                     pa_q   <= {ec_leaf_frame, va_q[PG_SHIFT-1:0]};
                     perm_q <= ec_perm;
                  end
                  state_q <= W_RESP;
               end
            end
            W_RESP:  state_q <= W_IDLE;
            default: state_q <= W_IDLE;
         endcase
      end
   end

   always_comb begin
      mem_addr = '0;
      case (state_q)
         W_DREQ: mem_addr = {base_q, va_q[31:22], 2'b00};
         W_LREQ: mem_addr = {pde_q[FW-1:0], va_q[21:12], 2'b00};
         default: mem_addr = '0;
      endcase
   end

   assign mem_req    = (state_q == W_DREQ) || (state_q == W_LREQ);
   assign miss_ready = (state_q == W_IDLE);
   assign rsp_valid  = (state_q == W_RESP);
   assign rsp_status = status_q;
   assign rsp_asid   = asid_q;
   assign rsp_va     = va_q;
   assign rsp_pa     = pa_q;
   assign rsp_perm   = perm_q;

   // R10: one request cycle per read
   p_req_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |=> !mem_req);

   // R8: busy after accepting a miss
   p_accept_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (miss_valid && miss_ready) |=> !miss_ready);

   // R8: response pulse is followed by idle
   p_rsp_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> (miss_ready && !rsp_valid));

   // R6: a granted translated write carries write permission
   p_write_perm_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_status == 2'd0 && xlate_q && wr_q) |-> rsp_perm[1]);

   // R7: passthrough echoes the address
   p_passthru_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !xlate_q) |-> (rsp_status == 2'd0 && rsp_pa[31:0] == rsp_va));

   // R4: leaf reads only follow a next-level directory entry
   p_leaf_after_dir_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == W_LREQ) |-> pde_q[BIT_NEXT]);

endmodule

// File: tb/iopt_walker_bench.sv
`timescale 1ns/1ps
module iopt_walker_bench;
   localparam int unsigned PA_BITS = 34;
   localparam int unsigned ASID_W  = 7;
   localparam int unsigned FW      = PA_BITS - 12;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic               cfg_idx_we = 0;
   logic [ASID_W-1:0]  cfg_idx_wdata = '0;
   logic               cfg_dat_we = 0;
   logic [31:0]        cfg_dat_wdata = '0;
   logic               miss_valid = 0;
   logic               miss_ready;
   logic [31:0]        miss_va = '0;
   logic [31:0]        miss_client_cfg = '0;
   logic               miss_write = 0;
   logic               mem_req;
   logic [PA_BITS-1:0] mem_addr;
   logic               mem_rvalid = 0;
   logic [31:0]        mem_rdata = '0;
   logic               rsp_valid;
   logic [1:0]         rsp_status;
   logic [ASID_W-1:0]  rsp_asid;
   logic [31:0]        rsp_va;
   logic [PA_BITS-1:0] rsp_pa;
   logic [2:0]         rsp_perm;

   iopt_walker #(.PA_BITS(PA_BITS), .ASID_W(ASID_W), .DIR_PERM_MERGE(1)) u_iopt_walker (
      .clk(clk), .rst_n(rst_n),
      .cfg_idx_we(cfg_idx_we), .cfg_idx_wdata(cfg_idx_wdata),
      .cfg_dat_we(cfg_dat_we), .cfg_dat_wdata(cfg_dat_wdata),
      .miss_valid(miss_valid), .miss_ready(miss_ready), .miss_va(miss_va),
      .miss_client_cfg(miss_client_cfg), .miss_write(miss_write),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
      .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_asid(rsp_asid),
      .rsp_va(rsp_va), .rsp_pa(rsp_pa), .rsp_perm(rsp_perm)
   );

   int checks = 0;
   int errors = 0;
   logic [31:0]        mem_m [logic [PA_BITS-1:0]];
   logic [FW-1:0]      bframe [128];
   bit                 bpres  [128];
   int                 nreads = 0;
   logic [PA_BITS-1:0] addr_log [4];
   bit                 done = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] mrd(input logic [PA_BITS-1:0] a);
      if (mem_m.exists(a)) return mem_m[a];
      return 32'd0;
   endfunction

   // memory responder: 1..7 cycle latency
   initial begin
      forever begin
         @(negedge clk);
         mem_rvalid = 1'b0;
         if (mem_req) begin
            int lat;
            logic [PA_BITS-1:0] a;
            a = mem_addr;
            if (nreads < 4) addr_log[nreads] = a;
            nreads++;
            lat = $urandom_range(0, 6);
            for (int k = 0; k <= lat; k++) begin
               @(negedge clk);
               if (k == 0) chk(!mem_req, "R10", "mem_req pulse", 64'(mem_req), 64'd0);
            end
            mem_rdata  = mrd(a);
            mem_rvalid = 1'b1;
         end
      end
   end

   task automatic cfg_idx(input int asid);
      @(negedge clk); cfg_idx_we = 1; cfg_idx_wdata = asid[ASID_W-1:0];
      @(negedge clk); cfg_idx_we = 0;
      cfg_idx_wdata = '0;
      bench_idx = asid;
   endtask

   int bench_idx = 0;

   task automatic cfg_dat(input logic [31:0] w);
      @(negedge clk); cfg_dat_we = 1; cfg_dat_wdata = w;
      @(negedge clk); cfg_dat_we = 0;
      bpres[bench_idx]  = (w != 32'd0);
      bframe[bench_idx] = w[FW-1:0];
   endtask

   task automatic do_walk(input logic [31:0] va, input logic [31:0] cid,
                          input logic wr, input string tag);
      logic [1:0] e_st; logic [PA_BITS-1:0] e_pa; logic [2:0] e_perm;
      int e_reads; logic [PA_BITS-1:0] e_a0, e_a1;
      logic [31:0] pde, pte; logic r, w; int asid; int n;
      e_st = 0; e_pa = '0; e_perm = 0; e_reads = 0; e_a0 = '0; e_a1 = '0;
      asid = int'(cid[6:0]);
      if (!cid[31]) begin
         e_pa = PA_BITS'(va);
      end else if (!bpres[asid]) begin
         e_st = 1;
      end else begin
         e_a0 = {bframe[asid], va[31:22], 2'b00};
         pde = mrd(e_a0); e_reads = 1;
         if (pde == 0 || !pde[28]) e_st = 1;
         else begin
            e_a1 = {pde[FW-1:0], va[21:12], 2'b00};
            pte = mrd(e_a1); e_reads = 2;
            r = pte[31] & pde[31]; w = pte[30] & pde[30];
            if (pte == 0) e_st = 1;
            else if (!(wr ? w : r)) e_st = 2;
            else begin e_pa = {pte[FW-1:0], va[11:0]}; e_perm = {r, w, pte[29]}; end
         end
      end
      @(negedge clk);
      nreads = 0;
      chk(miss_ready, "R8", {tag, " ready before miss"}, 64'(miss_ready), 64'd1);
      miss_valid = 1; miss_va = va; miss_client_cfg = cid; miss_write = wr;
      @(negedge clk);
      miss_valid = 0;
      n = 0;
      while (!rsp_valid && n < 200) begin @(negedge clk); n++; end
      chk(rsp_valid, "R10", {tag, " response arrives"}, 64'(rsp_valid), 64'd1);
      chk(rsp_status == e_st, e_st == 2 ? "R6" : (e_reads == 0 ? "R3" : "R4"),
          {tag, " status"}, 64'(rsp_status), 64'(e_st));
      chk(rsp_pa == e_pa, cid[31] ? "R2" : "R7", {tag, " pa"}, 64'(rsp_pa), 64'(e_pa));
      chk(rsp_perm == e_perm, "R9", {tag, " perm"}, 64'(rsp_perm), 64'(e_perm));
      chk(rsp_va == va && rsp_asid == cid[6:0], "R8", {tag, " echo"},
          {25'd0, rsp_asid, rsp_va}, {25'd0, cid[6:0], va});
      chk(nreads == e_reads, "R5", {tag, " read count"}, 64'(nreads), 64'(e_reads));
      if (e_reads >= 1) chk(addr_log[0] == e_a0, "R1", {tag, " dir addr"}, 64'(addr_log[0]), 64'(e_a0));
      if (e_reads == 2) chk(addr_log[1] == e_a1, "R2", {tag, " leaf addr"}, 64'(addr_log[1]), 64'(e_a1));
      chk(!miss_ready, "R8", {tag, " busy at response"}, 64'(miss_ready), 64'd0);
      @(negedge clk);
      chk(miss_ready && !rsp_valid, "R8", {tag, " idle after pulse"},
          {62'd0, miss_ready, rsp_valid}, 64'd2);
   endtask

   localparam logic [FW-1:0] BASE5 = 22'h312345;
   localparam logic [FW-1:0] BASE6 = 22'h000ABC;
   localparam logic [31:0]   EN    = 32'h8000_0000;

   function automatic logic [PA_BITS-1:0] dir_a(input logic [FW-1:0] b, input logic [9:0] d);
      return {b, d, 2'b00};
   endfunction
   function automatic logic [PA_BITS-1:0] leaf_a(input logic [FW-1:0] f, input logic [9:0] l);
      return {f, l, 2'b00};
   endfunction

   initial begin
      int seed;
      seed = $urandom(32'h5EED);
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk(miss_ready && !rsp_valid && !mem_req, "R8", "reset state",
          {61'd0, miss_ready, rsp_valid, mem_req}, 64'd4);

      // R3: index persists across two data writes; last one wins
      cfg_idx(5); cfg_dat(32'hE000_0000 | 32'(22'h111111)); cfg_dat(32'hE000_0000 | 32'(BASE5));
      cfg_idx(6); cfg_dat(32'hE000_0000 | 32'(BASE6));
      cfg_idx(10); cfg_dat(32'hE000_0000 | 32'(22'h2AAAAA)); cfg_dat(32'h0);

      // R7 passthrough, no reads
      do_walk(32'hDEAD_B123, 32'h0000_0005, 1'b1, "R7 passthrough");
      // R3 unprogrammed and cleared bases
      do_walk(32'h0040_1000, EN | 32'd9, 1'b0, "R3 never written");
      do_walk(32'h0040_1000, EN | 32'd10, 1'b0, "R3 cleared");
      // R4 zero directory entry, and one without next-level
      do_walk(32'h0080_0000, EN | 32'd5, 1'b0, "R4 zero dir");
      mem_m[dir_a(BASE5, 10'h003)] = 32'hE000_0000 | 32'(22'h3F0001);
      do_walk(32'h00C0_0000, EN | 32'd5, 1'b0, "R4 no next bit");
      // good directory at index 0x3FF
      mem_m[dir_a(BASE5, 10'h3FF)] = 32'hF000_0000 | 32'(22'h3C0F0F);
      do_walk(32'hFFC0_2000, EN | 32'd5, 1'b0, "R5 zero leaf");
      mem_m[leaf_a(22'h3C0F0F, 10'h003)] = 32'hA000_0000 | 32'(22'h2ABCDE);
      do_walk(32'hFFC0_3456, EN | 32'd5, 1'b1, "R6 write to read-only");
      do_walk(32'hFFC0_3456, EN | 32'd5, 1'b0, "R2 read refill");
      mem_m[leaf_a(22'h3C0F0F, 10'h004)] = 32'h4000_0000 | 32'(22'h000123);
      do_walk(32'hFFC0_4FFF, EN | 32'd5, 1'b0, "R6 read to write-only");
      // R6 merge: leaf grants write, directory does not
      mem_m[dir_a(BASE6, 10'h001)] = 32'hB000_0000 | 32'(22'h155555);
      mem_m[leaf_a(22'h155555, 10'h000)] = 32'hE000_0000 | 32'(22'h3FFFFF);
      do_walk(32'h0040_0ABC, EN | 32'd6, 1'b1, "R6 dir read-only");
      do_walk(32'h0040_0ABC, EN | 32'd6, 1'b0, "R9 merged perms");

      // random walks
      for (int i = 0; i < 300; i++) begin
         logic [31:0] va; logic [9:0] d; int asid; int t; logic [FW-1:0] lf; logic [31:0] pde;
         case ($urandom_range(0, 3))
            0: d = 10'h001; 1: d = 10'h2A5; 2: d = 10'h3FF; default: d = 10'h100;
         endcase
         va = {d, 22'($urandom)};
         t = $urandom_range(0, 9);
         asid = (t == 0) ? 9 : ((t < 5) ? 5 : 6);
         lf = FW'($urandom);
         case ($urandom_range(0, 5))
            0: pde = 32'h0;
            1: pde = {3'($urandom), 1'b0, 6'd0, lf};
            default: pde = {3'($urandom), 1'b1, 6'd0, lf};
         endcase
         if (asid != 9) mem_m[dir_a(bframe[asid], d)] = pde;
         if ($urandom_range(0, 5) == 0) mem_m[leaf_a(lf, va[21:12])] = 32'h0;
         else mem_m[leaf_a(lf, va[21:12])] = {3'($urandom), 7'd0, FW'($urandom)};
         do_walk(va, ($urandom_range(0, 7) == 0 ? 32'h0 : EN) | 32'(asid),
                 1'($urandom), "random");
      end

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule